// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a programmable sum-of-products device, together with the OR stage that sums its product terms. The AND array delivers eight product-term signals. Static configuration bits then decide how the sum reaches the pin. The path can be purely combinational or can go through a D flip-flop clocked by a shared clock. The sum can be inverted. The pin driver can be always on, or it can be gated by a dedicated product term. Depending on the configuration, the feedback line returned to the AND array carries either the pin level or the inverted register state.

A two-bit global mode code is shared by all cells and picks one of three families. In the simple family the outputs are combinational and always driven. In the complex family the outputs are combinational and product term 0 gates the pin driver. In the registered family each cell uses its own cell-mode bit to choose between the combinational tri-state form and a registered output. Each cell also has a polarity bit and a split bit. When the split bit is set in the registered form, the flip-flop loads the exclusive-OR of two separate partial sums instead of one plain sum. All configuration inputs are static control levels, and no data handshake is involved.

Top module: `omc_cell`

## Requirements
- R1: With global mode 2'b00 (simple), pin_oe is 1 and pin_out equals the OR of all eight product terms, XORed with inv (inv=1 inverts).
- R2: With global mode 2'b01 (complex), pin_oe equals product term 0 and pin_out equals the OR of terms 1 to 7, XORed with inv.
- R3: With global mode 2'b10 (registered) and cell_reg=0, the cell behaves exactly as in R2.
- R4: In every combinational configuration (any mode except registered with cell_reg=1), fb equals pin_in.
- R5: With global mode 2'b10 and cell_reg=1 (registered form), pin_out equals the flip-flop state, pin_oe equals product term 0, and fb equals the inverse of the flip-flop state.
- R6: In the registered form with split=0, the flip-flop loads (OR of terms 1 to 7) XOR inv on each rising clock edge.
- R7: In the registered form with split=1, the flip-flop loads (OR of terms 1 to 3) XOR (OR of terms 4 to 7) XOR inv. Outside the registered form, split has no effect on any output.
- R8: Outside the registered form, the flip-flop holds its value. On a return to the registered form, pin_out shows the held value before the next edge.
- R9: A synchronous reset (rst=1 at a rising edge) clears the flip-flop to 0, which takes priority over loading.
- R10: The reserved global mode code 2'b11 behaves exactly as simple mode (R1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all cells |
| rst | input | 1 | Synchronous reset of the flip-flop, active high |
| gmode | input | 2 | Global mode: 00 simple, 01 complex, 10 registered, 11 reserved (as simple) |
| cell_reg | input | 1 | Per-cell form in registered mode: 1 flip-flop, 0 combinational |
| inv | input | 1 | Polarity: 1 inverts the sum |
| split | input | 1 | Registered form only: load XOR of two partial sums |
| pt | input | 8 | Product terms; term 0 gates the driver in the tri-state families |
| pin_in | input | 1 | Level seen at the pin, used as feedback in combinational configurations |
| pin_out | output | 1 | Value offered to the pin driver |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback to the AND array |

## Verification
The checker module checks the port-level rules on every cycle. These cover the enable source for each family, pin feedback in combinational configurations, the inverted-register feedback and the pin value in the registered form, and the load, hold and reset behaviour of the flip-flop. Only the bench scenarios show the combinational truth values of each family and polarity under chosen term patterns. The bench scenarios also show that the reserved code matches simple mode, that split is ignored outside the registered form, and that a held register value is visible at the pin immediately after switching back.

// File: rtl/omc_pkg.sv
package omc_pkg;
  typedef enum logic [1:0] {
    GM_SIMPLE  = 2'b00,
    GM_COMPLEX = 2'b01,
    GM_REGIST  = 2'b10,
    GM_RESVD   = 2'b11
  } gmode_e;

  // Decoded form of one cell for a given global mode and cell bit.
  typedef enum logic [1:0] {
    CF_COMB_ON  = 2'b00,  // combinational, driver always on
    CF_COMB_TRI = 2'b01,  // combinational, term-gated driver
    CF_FLOP     = 2'b10   // registered, term-gated driver
  } cform_e;

  function automatic cform_e decode_form(input logic [1:0] gm, input logic creg);
    cform_e f;
    case (gm)
      GM_COMPLEX: f = CF_COMB_TRI;
      GM_REGIST:  f = creg ? CF_FLOP : CF_COMB_TRI;
      default:    f = CF_COMB_ON;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/omc_sum.sv
module omc_sum #(
  parameter int NT    = 8,
  parameter int SPLIT = NT / 2
) (
  input  logic [NT-1:0] pt,
  output logic          sum_all,
  output logic          sum_tail,
  output logic          sum_lo,
  output logic          sum_hi
);
  // Per-term membership in each partial sum, computed from the split point.
  logic [NT-1:0] m_tail, m_lo, m_hi;

  for (genvar i = 0; i < NT; i++) begin : g_mask
    if (i == 0) begin : g_oe_term
      assign m_tail[i] = 1'b0;
      assign m_lo[i]   = 1'b0;
      assign m_hi[i]   = 1'b0;
    end else if (i < SPLIT) begin : g_low
      assign m_tail[i] = pt[i];
      assign m_lo[i]   = pt[i];
      assign m_hi[i]   = 1'b0;
    end else begin : g_high
      assign m_tail[i] = pt[i];
      assign m_lo[i]   = 1'b0;
      assign m_hi[i]   = pt[i];
    end
  end

  assign sum_all  = |pt;
  assign sum_tail = |m_tail;
  assign sum_lo   = |m_lo;
  assign sum_hi   = |m_hi;
endmodule

// File: rtl/omc_reg.sv
module omc_reg (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/omc_route.sv
module omc_route
  import omc_pkg::*;
(
  input  logic [1:0] gmode,
  input  logic       cell_reg,
  input  logic       inv,
  input  logic       split,
  input  logic       oe_term,
  input  logic       sum_all,
  input  logic       sum_tail,
  input  logic       sum_lo,
  input  logic       sum_hi,
  input  logic       q,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb,
  output logic       d,
  output logic       load
);
  cform_e form;
  logic   flop_src;

  assign form     = decode_form(gmode, cell_reg);
  assign flop_src = split ? (sum_lo ^ sum_hi) : sum_tail;
  assign d        = flop_src ^ inv;
  assign load     = (form == CF_FLOP);

  always_comb begin
    case (form)
      CF_FLOP: begin
        pin_out = q;
        pin_oe  = oe_term;
        fb      = ~q;
      end
      CF_COMB_TRI: begin
        pin_out = sum_tail ^ inv;
        pin_oe  = oe_term;
        fb      = pin_in;
      end
      default: begin
        pin_out = sum_all ^ inv;
        pin_oe  = 1'b1;
        fb      = pin_in;
      end
    endcase
  end
endmodule

// File: rtl/omc_cell.sv
module omc_cell #(
  parameter int NT    = 8,
  parameter int SPLIT = NT / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    gmode,
  input  logic          cell_reg,
  input  logic          inv,
  input  logic          split,
  input  logic [NT-1:0] pt,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          fb
);
  logic s_all, s_tail, s_lo, s_hi;
  logic reg_q, reg_d, reg_load;

  omc_sum #(.NT(NT), .SPLIT(SPLIT)) u_sum (
    .pt(pt), .sum_all(s_all), .sum_tail(s_tail), .sum_lo(s_lo), .sum_hi(s_hi)
  );

  omc_route u_route (
    .gmode(gmode), .cell_reg(cell_reg), .inv(inv), .split(split),
    .oe_term(pt[0]), .sum_all(s_all), .sum_tail(s_tail), .sum_lo(s_lo),
    .sum_hi(s_hi), .q(reg_q), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .fb(fb), .d(reg_d), .load(reg_load)
  );

  omc_reg u_reg (
    .clk(clk), .rst(rst), .load(reg_load), .d(reg_d), .q(reg_q)
  );
endmodule

// File: rtl/omc_cell_chk.sv
module omc_cell_chk #(
  parameter int NT = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    gmode,
  input logic          cell_reg,
  input logic          inv,
  input logic          split,
  input logic [NT-1:0] pt,
  input logic          pin_in,
  input logic          pin_out,
  input logic          pin_oe,
  input logic          fb,
  input logic          q
);
  logic is_flop, is_tri;
  assign is_flop = (gmode == 2'b10) && cell_reg;
  assign is_tri  = (gmode == 2'b01) || ((gmode == 2'b10) && !cell_reg);

  // R1 and R10: simple and reserved codes always drive the pin
  p_simple_drives_r1: assert property (@(posedge clk) disable iff (rst)
    (gmode == 2'b00 || gmode == 2'b11) |-> pin_oe);

  // R2 and R3: tri-state families take the enable from term 0
  p_tri_enable_r2: assert property (@(posedge clk) disable iff (rst)
    is_tri |-> (pin_oe == pt[0]));

  p_pin_feedback_r4: assert property (@(posedge clk) disable iff (rst)
    !is_flop |-> (fb == pin_in));

  p_flop_pins_r5: assert property (@(posedge clk) disable iff (rst)
    is_flop |-> (pin_out == q && fb == !pin_out && pin_oe == pt[0]));

  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    (is_flop && !split) |=> (q == ($past(|pt[NT-1:1]) ^ $past(inv))));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !is_flop |=> $stable(q));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !q);
endmodule

bind omc_cell omc_cell_chk #(.NT(NT)) u_chk (
  .clk(clk), .rst(rst), .gmode(gmode), .cell_reg(cell_reg), .inv(inv),
  .split(split), .pt(pt), .pin_in(pin_in), .pin_out(pin_out),
  .pin_oe(pin_oe), .fb(fb), .q(reg_q)
);

// File: tb/test_omc_cell.sv
module test_omc_cell;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] gmode = 2'b10;
  logic       cell_reg = 1'b1, inv = 1'b0, split = 1'b0, pin_in = 1'b0;
  logic [7:0] pt = 8'hFF;
  logic       pin_out, pin_oe, fb;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  omc_cell i_omc_cell (
    .clk(clk), .rst(rst), .gmode(gmode), .cell_reg(cell_reg), .inv(inv),
    .split(split), .pt(pt), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .fb(fb)
  );

  // Vector: gm[16:15] creg[14] inv[13] split[12] pt[11:4] pin[3] out[2] oe[1] fb[0]
  localparam logic [16:0] TV [12] = '{
    {2'b00, 1'b0, 1'b0, 1'b0, 8'b0000_0000, 1'b0, 3'b010},  // R1
    {2'b00, 1'b0, 1'b0, 1'b0, 8'b0000_0001, 1'b1, 3'b111},  // R1 term0 summed
    {2'b00, 1'b0, 1'b1, 1'b0, 8'b0000_0001, 1'b0, 3'b010},  // R1 inverted
    {2'b00, 1'b0, 1'b1, 1'b0, 8'b0000_0000, 1'b1, 3'b111},  // R1 inverted
    {2'b01, 1'b0, 1'b0, 1'b0, 8'b0000_0001, 1'b0, 3'b010},  // R2 term0 not summed
    {2'b01, 1'b0, 1'b0, 1'b0, 8'b1000_0000, 1'b1, 3'b101},  // R2 driver off, R4
    {2'b01, 1'b0, 1'b1, 1'b0, 8'b0000_0011, 1'b0, 3'b010},  // R2 inverted
    {2'b01, 1'b0, 1'b1, 1'b0, 8'b0000_0000, 1'b1, 3'b101},  // R2 inverted, off
    {2'b10, 1'b0, 1'b0, 1'b0, 8'b0010_0001, 1'b1, 3'b111},  // R3
    {2'b10, 1'b0, 1'b1, 1'b0, 8'b0010_0000, 1'b0, 3'b000},  // R3 inverted, off
    {2'b11, 1'b0, 1'b0, 1'b0, 8'b0000_0001, 1'b0, 3'b110},  // R10
    {2'b00, 1'b1, 1'b0, 1'b1, 8'b0001_0010, 1'b1, 3'b111}   // R7 split ignored
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [1:0] g, input logic c, input logic iv,
                       input logic sp, input logic [7:0] p);
    gmode = g; cell_reg = c; inv = iv; split = sp; pt = p;
  endtask

  task automatic edge_then_settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset holds the register at zero despite all terms high
    repeat (3) @(negedge clk);
    check("R9 reset pin_out", pin_out, 1'b0);
    check("R9 reset fb", fb, 1'b1);
    check("R5 reset oe", pin_oe, 1'b1);
    rst = 1'b0;

    foreach (TV[k]) begin
      drive(TV[k][16:15], TV[k][14], TV[k][13], TV[k][12], TV[k][11:4]);
      pin_in = TV[k][3];
      #1;
      check($sformatf("vec%0d pin_out R1/R2/R3/R10", k), pin_out, TV[k][2]);
      check($sformatf("vec%0d pin_oe R1/R2/R3", k), pin_oe, TV[k][1]);
      check($sformatf("vec%0d fb R4", k), fb, TV[k][0]);
      @(negedge clk);
    end

    // R6: plain load
    drive(2'b10, 1'b1, 1'b0, 1'b0, 8'b0000_0011);
    edge_then_settle();
    check("R6 load 1 pin_out", pin_out, 1'b1);
    check("R5 fb inverted", fb, 1'b0);
    // R6 with polarity
    inv = 1'b1;
    edge_then_settle();
    check("R6 inverted load", pin_out, 1'b0);
    check("R5 fb inverted", fb, 1'b1);
    // R7: split sums
    drive(2'b10, 1'b1, 1'b0, 1'b1, 8'b0000_0010);
    edge_then_settle();
    check("R7 split low only", pin_out, 1'b1);
    drive(2'b10, 1'b1, 1'b0, 1'b1, 8'b0001_0010);
    edge_then_settle();
    check("R7 split both", pin_out, 1'b0);
    drive(2'b10, 1'b1, 1'b1, 1'b1, 8'b0001_0000);
    edge_then_settle();
    check("R7 split high inverted", pin_out, 1'b0);
    // R5: driver gated by term 0 while pin shows the register
    drive(2'b10, 1'b1, 1'b0, 1'b0, 8'b0100_0000);
    #1;
    check("R5 oe off", pin_oe, 1'b0);
    edge_then_settle();
    check("R5 pin_out with oe off", pin_out, 1'b1);

    // R8: hold outside registered form
    drive(2'b01, 1'b1, 1'b0, 1'b0, 8'b0000_0000);
    repeat (2) edge_then_settle();
    drive(2'b10, 1'b0, 1'b0, 1'b0, 8'b0000_0000);
    repeat (2) edge_then_settle();
    drive(2'b10, 1'b1, 1'b0, 1'b0, 8'b0000_0001);
    #1;
    check("R8 held value visible", pin_out, 1'b1);
    check("R8 held fb", fb, 1'b0);

    // R9: reset wins over a load of 1
    drive(2'b10, 1'b1, 1'b0, 1'b0, 8'b0000_0011);
    rst = 1'b1;
    edge_then_settle();
    check("R9 reset over load", pin_out, 1'b0);
    rst = 1'b0;
    edge_then_settle();
    check("R6 load after reset", pin_out, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule